// File: doc/BRIEF.md
# Branch Trace History Buffer

This block keeps a short history of the taken branches of a processor core. For each accepted branch it stores a source and destination program-counter pair in a ring of sixteen slots. Software drains the history through three 32-bit registers, newest branch first. Each entry comes out as two consecutive reads of one data register: the destination first, then the source.

The core presents a one-cycle branch strobe together with both PCs, a flag that marks branches made by zero-overhead hardware loops, and its current interrupt level. Recording is gated in several ways. It needs the power bit and the enable bit. It skips loop branches and the reset level. In exception mode it also skips the lowest interrupt levels.

When the ring is full, the block either discards the oldest pair or drops the new branch and pulses an overflow exception. Optional compression folds a repeat of the newest or second-newest pair into that pair by setting its bit 0, so tight loops do not flood the history.

Top module: `branch_hist_buf`

## Requirements
- R1: After reset the control register reads 0, the status register reads 0, a data read returns 0 and `ovf_exc` is low.
- R2: A branch is recorded only when control bit 0 (power) and control bit 1 (enable) are both 1.
- R3: A branch with `br_hwloop` high is never recorded. A branch at interrupt level 1 (the reset level) is never recorded.
- R4: When control bit 2 (exception mode) is 1, a branch at interrupt level 0 to 3 is not recorded. With bit 2 at 0, those levels record normally.
- R5: When 16 entries are held and exception mode is set, a further recordable branch is dropped. `ovf_exc` is high for the cycle after that branch is presented, and the count stays 16.
- R6: When 16 entries are held and exception mode is clear, a further branch discards the oldest entry, and the newest pairs remain readable.
- R7: With control bit 3 (one-level compression) set and at least one entry held, a branch equal to the newest entry with bit 0 of both stored values ignored is not stored. Bit 0 of that entry's destination is set instead.
- R8: With control bit 4 (two-level compression) set and at least two entries held, a branch equal to the second-newest entry with bit 0 ignored is not stored. Bit 0 of that entry's source is set instead. When both compressions could apply, only the one-level merge happens.
- R9: A data read (offset 0x100) on an empty buffer returns 0. Otherwise reads alternate: the first returns the newest destination, the second returns its source and removes that entry. Read data appears on `bus_rdata` in the cycle after the access.
- R10: A status read (offset 0x004) returns the number of held entries, limited to 16. The control register is at offset 0x000.
- R11: Writes to the status and data offsets change nothing. A control write stores bits 4:0, and reading the control register back returns those bits with all higher bits zero.
- R12: An access with `bus_word` low, or to any offset other than 0x000, 0x004 or 0x100, raises `bus_err` in the next cycle with `bus_rdata` 0, and it changes no state.
- R13: The full-buffer step runs before compression. In overwrite mode a branch that arrives when the ring is full and is then merged still removes the oldest entry, so the count drops to 15.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| br_valid | input | 1 | Taken-branch strobe, one cycle per branch |
| br_src | input | 32 | Branch source PC |
| br_dst | input | 32 | Branch destination PC |
| br_hwloop | input | 1 | Branch produced by a hardware loop |
| br_level | input | 4 | Current interrupt level of the core |
| bus_sel | input | 1 | Register access strobe |
| bus_write | input | 1 | 1 = write, 0 = read |
| bus_word | input | 1 | 1 = full 32-bit access |
| bus_addr | input | 9 | Register byte offset |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, valid the cycle after a read |
| bus_err | output | 1 | Invalid access flag, the cycle after the access |
| ovf_exc | output | 1 | Overflow exception pulse |

## Verification
The bench drives the ring past full in both policies. A design that overwrote in exception mode, or raised no pulse, would show the wrong newest entry or a silent `ovf_exc`. It checks that an overwrite followed by a merge leaves 15 entries, which catches a design that compresses before it makes room. Merges are read back with their bit 0 marks, including a case where both compressions match, so a design that flagged the wrong half or let the two-level check win would return different values. Filtered branches and ignored or malformed accesses are followed by status and control reads, which expose any state they touched.

// File: rtl/brh_pkg.sv
package brh_pkg;
    localparam int PC_W  = 32;
    localparam int LVL_W = 4;
    localparam int OFS_W = 9;

    localparam logic [LVL_W-1:0] LVL_RESET     = 4'd1;
    localparam logic [LVL_W-1:0] LVL_GUARD_TOP = 4'd3;

    localparam logic [OFS_W-1:0] OFS_CTRL = 9'h000;
    localparam logic [OFS_W-1:0] OFS_STAT = 9'h004;
    localparam logic [OFS_W-1:0] OFS_DATA = 9'h100;

    localparam int STAT_CAP = 16;

    typedef struct packed {
        logic [PC_W-1:0] src;
        logic [PC_W-1:0] dst;
    } hist_ent_t;

    // bit 0 power, 1 enable, 2 exception mode, 3 one-level, 4 two-level
    typedef struct packed {
        logic cmp2;
        logic cmp1;
        logic exc_mode;
        logic enable;
        logic power;
    } ctl_t;
endpackage

// File: rtl/brh_gate.sv
module brh_gate
    import brh_pkg::*;
(
    input  ctl_t             ctl_i,
    input  logic             valid_i,
    input  logic             hwloop_i,
    input  logic [LVL_W-1:0] level_i,
    output logic             take_o
);
    logic armed;
    logic lvl_ok;

    always_comb begin
        armed  = ctl_i.power && ctl_i.enable;
        lvl_ok = (level_i != LVL_RESET) &&
                 !(ctl_i.exc_mode && (level_i <= LVL_GUARD_TOP));
        take_o = valid_i && armed && !hwloop_i && lvl_ok;
    end
endmodule

// File: rtl/brh_ring.sv
module brh_ring
    import brh_pkg::*;
#(
    parameter int DEPTH_LOG2 = 4
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  push_i,
    input  logic [PC_W-1:0]       src_i,
    input  logic [PC_W-1:0]       dst_i,
    input  logic                  exc_mode_i,
    input  logic                  cmp1_i,
    input  logic                  cmp2_i,
    input  logic                  pop_i,
    output logic [DEPTH_LOG2:0]   count_o,
    output logic [PC_W-1:0]       pop_val_o,
    output logic                  exc_o
);
    localparam int DEPTH = 1 << DEPTH_LOG2;
    localparam int PW    = DEPTH_LOG2 + 1;
    localparam logic [PW-1:0]         FULL   = PW'(DEPTH);
    localparam logic [PW-1:0]         P_ONE  = PW'(1);
    localparam logic [PW-1:0]         P_TWO  = PW'(2);
    localparam logic [DEPTH_LOG2-1:0] I_ONE  = DEPTH_LOG2'(1);
    localparam logic [DEPTH_LOG2-1:0] I_TWO  = DEPTH_LOG2'(2);

    typedef struct packed {
        hist_ent_t [DEPTH-1:0] ent;
        logic [PW-1:0]         top;
        logic [PW-1:0]         bot;
        logic                  mid;
        logic                  exc;
    } ring_t;

    ring_t q, d;

    logic [PW-1:0]         cnt_q, cnt_p;
    logic [DEPTH_LOG2-1:0] last_q, last_p, prev_p, slot_p;
    logic                  drop;

    function automatic logic same_pair(hist_ent_t e, logic [PC_W-1:0] s,
                                       logic [PC_W-1:0] t);
        return (s == {e.src[PC_W-1:1], 1'b0}) && (t == {e.dst[PC_W-1:1], 1'b0});
    endfunction

    always_comb begin
        d      = q;
        d.exc  = 1'b0;
        drop   = 1'b0;

        // read side works on the registered state
        cnt_q     = q.top - q.bot;
        last_q    = q.top[DEPTH_LOG2-1:0] - I_ONE;
        pop_val_o = '0;
        if (cnt_q != '0) begin
            pop_val_o = q.mid ? q.ent[last_q].src : q.ent[last_q].dst;
        end
        if (pop_i && (cnt_q != '0)) begin
            if (q.mid) begin
                d.top = q.top - P_ONE;
            end
            d.mid = !q.mid;
        end

        // branch side sees the state after any pop
        cnt_p  = d.top - d.bot;
        slot_p = d.top[DEPTH_LOG2-1:0];
        last_p = slot_p - I_ONE;
        prev_p = slot_p - I_TWO;
        if (push_i) begin
            if (cnt_p == FULL) begin
                if (exc_mode_i) begin
                    d.exc = 1'b1;
                    drop  = 1'b1;
                end else begin
                    d.bot = d.bot + P_ONE;
                end
            end
            if (!drop) begin
                if (cmp1_i && (cnt_p >= P_ONE) && same_pair(d.ent[last_p], src_i, dst_i)) begin
                    d.ent[last_p].dst[0] = 1'b1;
                end else if (cmp2_i && (cnt_p >= P_TWO) &&
                             same_pair(d.ent[prev_p], src_i, dst_i)) begin
                    d.ent[prev_p].src[0] = 1'b1;
                end else begin
                    d.ent[slot_p] = '{src: src_i, dst: dst_i};
                    d.top         = d.top + P_ONE;
                end
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            q <= '0;
        end else begin
            q <= d;
        end
    end

    assign count_o = q.top - q.bot;
    assign exc_o   = q.exc;

    p_exc_cause_r5: assert property (@(posedge clk) disable iff (!rst_n)
        q.exc |-> $past(push_i && exc_mode_i));

    p_pop_step_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (pop_i && !push_i && q.mid && (count_o != '0)) |=> (q.top == $past(q.top) - P_ONE));

    p_overwrite_keeps_full_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (push_i && !exc_mode_i && !pop_i && (count_o == FULL)) |=> (count_o >= FULL - P_ONE));
endmodule

// File: rtl/brh_regif.sv
module brh_regif
    import brh_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             sel_i,
    input  logic             write_i,
    input  logic             word_i,
    input  logic [OFS_W-1:0] addr_i,
    input  logic [31:0]      ctrl_val_i,
    input  logic [31:0]      stat_val_i,
    input  logic [31:0]      data_val_i,
    output logic             ctrl_we_o,
    output logic             data_pop_o,
    output logic [31:0]      rdata_o,
    output logic             err_o
);
    typedef struct packed {
        logic [31:0] rdata;
        logic        err;
    } port_t;

    port_t q, d;
    logic  known, bad, good;

    always_comb begin
        known = (addr_i == OFS_CTRL) || (addr_i == OFS_STAT) || (addr_i == OFS_DATA);
        bad   = sel_i && (!word_i || !known);
        good  = sel_i && !bad;

        ctrl_we_o  = good && write_i && (addr_i == OFS_CTRL);
        data_pop_o = good && !write_i && (addr_i == OFS_DATA);

        d     = q;
        d.err = bad;
        if (sel_i) begin
            d.rdata = '0;
            if (good && !write_i) begin
                unique case (addr_i)
                    OFS_CTRL: d.rdata = ctrl_val_i;
                    OFS_STAT: d.rdata = stat_val_i;
                    default:  d.rdata = data_val_i;
                endcase
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            q <= '0;
        end else begin
            q <= d;
        end
    end

    assign rdata_o = q.rdata;
    assign err_o   = q.err;

    p_err_zero_data_r12: assert property (@(posedge clk) disable iff (!rst_n)
        err_o |-> (rdata_o == '0));

    p_err_needs_access_r12: assert property (@(posedge clk) disable iff (!rst_n)
        err_o |-> $past(sel_i));
endmodule

// File: rtl/branch_hist_buf.sv
module branch_hist_buf
    import brh_pkg::*;
#(
    parameter int DEPTH_LOG2 = 4
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        br_valid,
    input  logic [31:0] br_src,
    input  logic [31:0] br_dst,
    input  logic        br_hwloop,
    input  logic [3:0]  br_level,
    input  logic        bus_sel,
    input  logic        bus_write,
    input  logic        bus_word,
    input  logic [8:0]  bus_addr,
    input  logic [31:0] bus_wdata,
    output logic [31:0] bus_rdata,
    output logic        bus_err,
    output logic        ovf_exc
);
    localparam int DEPTH = 1 << DEPTH_LOG2;
    localparam logic [DEPTH_LOG2:0] FULL = (DEPTH_LOG2+1)'(DEPTH);

    ctl_t ctl_q, ctl_d;

    logic                  take;
    logic                  ctrl_we;
    logic                  data_pop;
    logic [DEPTH_LOG2:0]   count;
    logic [31:0]           pop_val;
    logic [31:0]           count_w;
    logic [31:0]           stat_val;
    logic [31:0]           ctrl_val;
    logic                  unused_wdata;

    assign unused_wdata = ^bus_wdata[31:5];

    always_comb begin
        ctl_d = ctl_q;
        if (ctrl_we) begin
            ctl_d = ctl_t'(bus_wdata[4:0]);
        end
        count_w  = 32'(count);
        stat_val = (count_w > 32'(STAT_CAP)) ? 32'(STAT_CAP) : count_w;
        ctrl_val = {27'd0, ctl_q};
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ctl_q <= '0;
        end else begin
            ctl_q <= ctl_d;
        end
    end

    brh_gate u_gate (
        .ctl_i    (ctl_q),
        .valid_i  (br_valid),
        .hwloop_i (br_hwloop),
        .level_i  (br_level),
        .take_o   (take)
    );

    brh_ring #(.DEPTH_LOG2(DEPTH_LOG2)) u_ring (
        .clk        (clk),
        .rst_n      (rst_n),
        .push_i     (take),
        .src_i      (br_src),
        .dst_i      (br_dst),
        .exc_mode_i (ctl_q.exc_mode),
        .cmp1_i     (ctl_q.cmp1),
        .cmp2_i     (ctl_q.cmp2),
        .pop_i      (data_pop),
        .count_o    (count),
        .pop_val_o  (pop_val),
        .exc_o      (ovf_exc)
    );

    brh_regif u_regif (
        .clk        (clk),
        .rst_n      (rst_n),
        .sel_i      (bus_sel),
        .write_i    (bus_write),
        .word_i     (bus_word),
        .addr_i     (bus_addr),
        .ctrl_val_i (ctrl_val),
        .stat_val_i (stat_val),
        .data_val_i (pop_val),
        .ctrl_we_o  (ctrl_we),
        .data_pop_o (data_pop),
        .rdata_o    (bus_rdata),
        .err_o      (bus_err)
    );

    p_gate_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (!(ctl_q.power && ctl_q.enable) && !data_pop) |=> $stable(count));

    p_loop_skip_r3: assert property (@(posedge clk) disable iff (!rst_n)
        ((br_hwloop || (br_level == LVL_RESET)) && !data_pop) |=> $stable(count));

    p_low_level_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (ctl_q.exc_mode && (br_level <= LVL_GUARD_TOP) && !data_pop) |=> $stable(count));

    p_count_cap_r10: assert property (@(posedge clk) disable iff (!rst_n)
        count <= FULL);
endmodule

// File: tb/test_branch_hist_buf.sv
`timescale 1ns/1ps
module test_branch_hist_buf;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        br_valid = 1'b0;
    logic [31:0] br_src = '0;
    logic [31:0] br_dst = '0;
    logic        br_hwloop = 1'b0;
    logic [3:0]  br_level = 4'd6;
    logic        bus_sel = 1'b0;
    logic        bus_write = 1'b0;
    logic        bus_word = 1'b1;
    logic [8:0]  bus_addr = '0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic        bus_err;
    logic        ovf_exc;

    int n_chk = 0;
    int n_bad = 0;

    always #10 clk = ~clk;

    branch_hist_buf i_branch_hist_buf (
        .clk(clk), .rst_n(rst_n),
        .br_valid(br_valid), .br_src(br_src), .br_dst(br_dst),
        .br_hwloop(br_hwloop), .br_level(br_level),
        .bus_sel(bus_sel), .bus_write(bus_write), .bus_word(bus_word),
        .bus_addr(bus_addr), .bus_wdata(bus_wdata),
        .bus_rdata(bus_rdata), .bus_err(bus_err), .ovf_exc(ovf_exc)
    );

    localparam logic [1:0] OP_WR = 2'd0;
    localparam logic [1:0] OP_RD = 2'd1;
    localparam logic [1:0] OP_BR = 2'd2;

    typedef struct packed {
        logic [1:0]  op;
        logic [8:0]  ofs;
        logic [31:0] a;
        logic [31:0] b;
        logic [3:0]  lvl;
        logic        hw;
        logic [31:0] exp;
        logic [7:0]  rq;
    } vec_t;

    localparam int NV = 39;
    localparam vec_t TBL [NV] = '{
        '{OP_WR, 9'h000, 32'h03,  32'h0,   4'd6, 1'b0, 32'h0,   8'd2},
        '{OP_BR, 9'h000, 32'h100, 32'h200, 4'd6, 1'b0, 32'h0,   8'd2},
        '{OP_BR, 9'h000, 32'h300, 32'h400, 4'd6, 1'b1, 32'h0,   8'd3},  // R3 loop
        '{OP_BR, 9'h000, 32'h500, 32'h600, 4'd1, 1'b0, 32'h0,   8'd3},  // R3 reset level
        '{OP_RD, 9'h004, 32'h0,   32'h0,   4'd6, 1'b0, 32'd1,   8'd3},
        '{OP_BR, 9'h000, 32'h700, 32'h800, 4'd2, 1'b0, 32'h0,   8'd4},
        '{OP_RD, 9'h004, 32'h0,   32'h0,   4'd6, 1'b0, 32'd2,   8'd4},  // R4 low level ok without mode
        '{OP_RD, 9'h100, 32'h0,   32'h0,   4'd6, 1'b0, 32'h800, 8'd9},
        '{OP_RD, 9'h100, 32'h0,   32'h0,   4'd6, 1'b0, 32'h700, 8'd9},
        '{OP_RD, 9'h004, 32'h0,   32'h0,   4'd6, 1'b0, 32'd1,   8'd10},
        '{OP_RD, 9'h100, 32'h0,   32'h0,   4'd6, 1'b0, 32'h200, 8'd9},
        '{OP_RD, 9'h100, 32'h0,   32'h0,   4'd6, 1'b0, 32'h100, 8'd9},
        '{OP_RD, 9'h100, 32'h0,   32'h0,   4'd6, 1'b0, 32'h0,   8'd9},  // R9 empty
        '{OP_RD, 9'h004, 32'h0,   32'h0,   4'd6, 1'b0, 32'd0,   8'd10},
        '{OP_WR, 9'h000, 32'h07,  32'h0,   4'd6, 1'b0, 32'h0,   8'd4},
        '{OP_BR, 9'h000, 32'h10,  32'h20,  4'd3, 1'b0, 32'h0,   8'd4},
        '{OP_RD, 9'h004, 32'h0,   32'h0,   4'd6, 1'b0, 32'd0,   8'd4},  // R4 blocked
        '{OP_BR, 9'h000, 32'h10,  32'h20,  4'd4, 1'b0, 32'h0,   8'd4},
        '{OP_RD, 9'h004, 32'h0,   32'h0,   4'd6, 1'b0, 32'd1,   8'd4},
        '{OP_WR, 9'h000, 32'h0B,  32'h0,   4'd6, 1'b0, 32'h0,   8'd7},
        '{OP_BR, 9'h000, 32'h10,  32'h20,  4'd6, 1'b0, 32'h0,   8'd7},
        '{OP_RD, 9'h004, 32'h0,   32'h0,   4'd6, 1'b0, 32'd1,   8'd7},  // R7 merged
        '{OP_BR, 9'h000, 32'h30,  32'h40,  4'd6, 1'b0, 32'h0,   8'd7},
        '{OP_WR, 9'h000, 32'h13,  32'h0,   4'd6, 1'b0, 32'h0,   8'd8},
        '{OP_BR, 9'h000, 32'h10,  32'h20,  4'd6, 1'b0, 32'h0,   8'd8},
        '{OP_RD, 9'h004, 32'h0,   32'h0,   4'd6, 1'b0, 32'd2,   8'd8},  // R8 merged
        '{OP_RD, 9'h100, 32'h0,   32'h0,   4'd6, 1'b0, 32'h40,  8'd9},
        '{OP_RD, 9'h100, 32'h0,   32'h0,   4'd6, 1'b0, 32'h30,  8'd9},
        '{OP_RD, 9'h100, 32'h0,   32'h0,   4'd6, 1'b0, 32'h21,  8'd7},
        '{OP_RD, 9'h100, 32'h0,   32'h0,   4'd6, 1'b0, 32'h11,  8'd8},
        '{OP_WR, 9'h000, 32'h01,  32'h0,   4'd6, 1'b0, 32'h0,   8'd2},
        '{OP_BR, 9'h000, 32'h50,  32'h60,  4'd6, 1'b0, 32'h0,   8'd2},
        '{OP_RD, 9'h004, 32'h0,   32'h0,   4'd6, 1'b0, 32'd0,   8'd2},  // R2 power only
        '{OP_WR, 9'h004, 32'h55,  32'h0,   4'd6, 1'b0, 32'h0,   8'd11},
        '{OP_RD, 9'h004, 32'h0,   32'h0,   4'd6, 1'b0, 32'd0,   8'd11},
        '{OP_RD, 9'h000, 32'h0,   32'h0,   4'd6, 1'b0, 32'h01,  8'd11},
        '{OP_WR, 9'h000, 32'hFFFFFFFF, 32'h0, 4'd6, 1'b0, 32'h0, 8'd11},
        '{OP_RD, 9'h000, 32'h0,   32'h0,   4'd6, 1'b0, 32'h1F,  8'd11}, // R11 upper bits zero
        '{OP_WR, 9'h000, 32'h00,  32'h0,   4'd6, 1'b0, 32'h0,   8'd11}
    };

    task automatic check(input logic [31:0] act, input logic [31:0] exp, input string tag);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic do_branch(input logic [31:0] s, input logic [31:0] t,
                             input logic [3:0] l, input logic h, output logic exc);
        @(negedge clk);
        br_valid = 1'b1; br_src = s; br_dst = t; br_level = l; br_hwloop = h;
        @(negedge clk);
        br_valid = 1'b0; br_hwloop = 1'b0;
        exc = ovf_exc;
    endtask

    task automatic reg_wr(input logic [8:0] ofs, input logic [31:0] v,
                          input logic word, output logic err);
        @(negedge clk);
        bus_sel = 1'b1; bus_write = 1'b1; bus_word = word; bus_addr = ofs; bus_wdata = v;
        @(negedge clk);
        bus_sel = 1'b0; bus_write = 1'b0; bus_word = 1'b1;
        err = bus_err;
    endtask

    task automatic reg_rd(input logic [8:0] ofs, input logic word,
                          output logic [31:0] v, output logic err);
        @(negedge clk);
        bus_sel = 1'b1; bus_write = 1'b0; bus_word = word; bus_addr = ofs;
        @(negedge clk);
        bus_sel = 1'b0; bus_word = 1'b1;
        v = bus_rdata;
        err = bus_err;
    endtask

    task automatic finish_run();
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        n_chk++;
        n_bad++;
        $display("FAIL watchdog (all requirements) actual=hang expected=finish");
        finish_run();
    end

    initial begin
        logic [31:0] v;
        logic        e;
        logic        x;

        repeat (3) @(negedge clk);
        rst_n = 1'b1;

        // R1 reset state
        check({31'd0, ovf_exc}, 32'd0, "R1 exception low");
        reg_rd(9'h000, 1'b1, v, e); check(v, 32'h0, "R1 control");
        reg_rd(9'h004, 1'b1, v, e); check(v, 32'h0, "R1 status");
        reg_rd(9'h100, 1'b1, v, e); check(v, 32'h0, "R1 data");

        // R12 invalid accesses
        reg_rd(9'h008, 1'b1, v, e);
        check({31'd0, e}, 32'd1, "R12 bad offset err");
        check(v, 32'h0, "R12 bad offset data");
        reg_wr(9'h000, 32'h03, 1'b0, e);
        check({31'd0, e}, 32'd1, "R12 narrow write err");
        reg_rd(9'h000, 1'b1, v, e); check(v, 32'h0, "R12 narrow write no effect");
        check({31'd0, e}, 32'd0, "R12 good read no err");

        // vector table
        for (int k = 0; k < NV; k++) begin
            case (TBL[k].op)
                OP_WR: reg_wr(TBL[k].ofs, TBL[k].a, 1'b1, e);
                OP_BR: do_branch(TBL[k].a, TBL[k].b, TBL[k].lvl, TBL[k].hw, x);
                default: begin
                    reg_rd(TBL[k].ofs, 1'b1, v, e);
                    check(v, TBL[k].exp, $sformatf("R%0d vector %0d", TBL[k].rq, k));
                end
            endcase
        end

        // R11 data offset write ignored
        reg_wr(9'h000, 32'h03, 1'b1, e);
        do_branch(32'h900, 32'hA00, 4'd6, 1'b0, x);
        reg_wr(9'h100, 32'h1234, 1'b1, e);
        reg_rd(9'h004, 1'b1, v, e); check(v, 32'd1, "R11 data write ignored");
        reg_rd(9'h100, 1'b1, v, e); check(v, 32'hA00, "R11 entry intact dst");
        reg_rd(9'h100, 1'b1, v, e); check(v, 32'h900, "R11 entry intact src");

        // R6 overwrite when full
        for (int i = 0; i < 20; i++)
            do_branch(32'h1000 + 32'(8*i), 32'h2000 + 32'(8*i), 4'd6, 1'b0, x);
        reg_rd(9'h004, 1'b1, v, e); check(v, 32'd16, "R6 status full");
        for (int i = 19; i >= 4; i--) begin
            reg_rd(9'h100, 1'b1, v, e); check(v, 32'h2000 + 32'(8*i), "R6 dst order");
            reg_rd(9'h100, 1'b1, v, e); check(v, 32'h1000 + 32'(8*i), "R6 src order");
        end
        reg_rd(9'h004, 1'b1, v, e); check(v, 32'd0, "R6 drained");

        // R5 exception mode when full
        reg_wr(9'h000, 32'h07, 1'b1, e);
        for (int i = 0; i < 16; i++) begin
            do_branch(32'h5000 + 32'(8*i), 32'h6000 + 32'(8*i), 4'd6, 1'b0, x);
            if (i == 15) check({31'd0, x}, 32'd0, "R5 no pulse before full");
        end
        do_branch(32'h7000, 32'h7100, 4'd6, 1'b0, x);
        check({31'd0, x}, 32'd1, "R5 pulse on drop");
        reg_rd(9'h004, 1'b1, v, e); check(v, 32'd16, "R5 count held");
        check({31'd0, ovf_exc}, 32'd0, "R5 pulse ends");
        reg_rd(9'h100, 1'b1, v, e); check(v, 32'h6078, "R5 newest kept");
        for (int i = 0; i < 31; i++) reg_rd(9'h100, 1'b1, v, e);
        reg_rd(9'h004, 1'b1, v, e); check(v, 32'd0, "R5 drained");

        // R13 full step precedes compression
        reg_wr(9'h000, 32'h0B, 1'b1, e);
        for (int i = 0; i < 16; i++)
            do_branch(32'h3000 + 32'(8*i), 32'h4000 + 32'(8*i), 4'd6, 1'b0, x);
        do_branch(32'h3078, 32'h4078, 4'd6, 1'b0, x);
        reg_rd(9'h004, 1'b1, v, e); check(v, 32'd15, "R13 oldest dropped on merge");
        reg_rd(9'h100, 1'b1, v, e); check(v, 32'h4079, "R13 newest marked");
        for (int i = 0; i < 29; i++) reg_rd(9'h100, 1'b1, v, e);
        reg_rd(9'h004, 1'b1, v, e); check(v, 32'd0, "R13 drained");

        // R8 one-level wins when both match
        reg_wr(9'h000, 32'h03, 1'b1, e);
        do_branch(32'hA0, 32'hB0, 4'd6, 1'b0, x);
        do_branch(32'hA0, 32'hB0, 4'd6, 1'b0, x);
        reg_wr(9'h000, 32'h1B, 1'b1, e);
        do_branch(32'hA0, 32'hB0, 4'd6, 1'b0, x);
        reg_rd(9'h004, 1'b1, v, e); check(v, 32'd2, "R8 merged not stored");
        reg_rd(9'h100, 1'b1, v, e); check(v, 32'hB1, "R8 newest dst marked");
        reg_rd(9'h100, 1'b1, v, e); check(v, 32'hA0, "R8 newest src clean");
        reg_rd(9'h100, 1'b1, v, e); check(v, 32'hB0, "R8 older dst clean");
        reg_rd(9'h100, 1'b1, v, e); check(v, 32'hA0, "R8 older src clean");

        // R1 reset mid-run
        do_branch(32'hC0, 32'hD0, 4'd6, 1'b0, x);
        @(negedge clk); rst_n = 1'b0;
        @(negedge clk); rst_n = 1'b1;
        reg_rd(9'h004, 1'b1, v, e); check(v, 32'd0, "R1 status after reset");
        reg_rd(9'h000, 1'b1, v, e); check(v, 32'd0, "R1 control after reset");

        finish_run();
    end
endmodule